// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is the command interpreter of a byte-wide flash memory with sector erase. It has a 19-bit address and an 8-bit data bus, and runs synchronously to a system clock. The active-low chip select, output enable and write enable strobes are sampled on that clock. A write cycle starts when its strobe combination first appears. Data bytes written by the host are decoded as commands:

- program setup followed by the byte to program;
- sector-erase setup followed by its confirm code;
- chip-erase setup followed by a second chip-erase code;
- abort;
- entry into identification mode.

Program and erase run for a fixed number of clock cycles, each set by a parameter. A small register array stands in for the nonvolatile cells.

While an operation runs, every read returns a status byte. Bit 7 is the inverse of the final value of bit 7 at the location being written, and bit 6 flips after each read. The host therefore polls either bit until it sees true data. Writes are accepted only while the `unlock` input is high. That input comes from a separate protection detector that watches read-address sequences.

Top module: `flashcmd_seq`

## Requirements
- R1: A write cycle is recognised on the first clock at which cs_n=0, we_n=0 and oe_n=1. It ends when that combination ends. If oe_n is low, or cs_n or we_n is high, no command is taken.
- R2: While unlock is 0, every write cycle is ignored. No mode changes and the array is untouched.
- R3: Data 90h enters identification mode. A read there returns BFh at address 0, 04h at address 1 and 00h at any other address. FFh, or any other entry code (10h, 20h, 30h), leaves this mode and takes effect.
- R4: Data 10h arms programming. The next write cycle latches its address and data, and the cell becomes old AND new, because programming only clears bits.
- R5: Data 20h followed by D0h erases to FFh every implemented byte whose address bits from 8 upward match the confirm write. Other bytes keep their contents.
- R6: Data 30h followed by a second 30h sets every byte of the array to FFh.
- R7: FFh written after any setup code returns the block to read mode with memory unchanged. After an erase setup, any data other than its confirm code also abandons the sequence without effect.
- R8: While an operation runs, any read returns a status byte. Bit 7 is the inverse of the final value of bit 7 at the target location (program: old AND new; erase: 1). Bits 5..0 are the current array bits at the read address.
- R9: Status bit 6 is 0 when an operation starts and inverts at the end of every read cycle during the operation.
- R10: An operation stays active for exactly T_PROG, T_SECT or T_CHIP clocks after the clock that recognised its final write. Its effect lands at the last of those clocks, and write cycles during it are ignored.
- R11: dout_en is high exactly while cs_n=0, oe_n=0 and we_n=1. dout follows addr combinationally.
- R12: After reset the block is in read mode, the whole array holds FFh and the toggle bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| unlock | input | 1 | Write permission from the protection detector |
| addr | input | 19 | Byte address |
| din | input | 8 | Data written by the host |
| dout | output | 8 | Read data, identification code or status byte |
| dout_en | output | 1 | Drive enable for the shared data bus |

## Verification
A wrong mode shows up on the very next read cycle. It appears as an identification code where array data belongs, or as array data where a status byte belongs. Timer errors show up in the one clock where status gives way to true data, so the reference model is compared on every clock to catch a single-cycle early or late finish. Array corruption appears only when the affected address is read back. For that reason, the bench rereads bytes both inside and outside each erased sector and every programmed byte.

// File: rtl/flashcmd_pkg.sv
`timescale 1ns/1ps
package flashcmd_pkg;

    localparam int ADDR_W   = 19;
    localparam int DATA_W   = 8;
    localparam int SECT_LSB = 8;   // sector = address bits from here upward

    localparam logic [DATA_W-1:0] CMD_PROG       = 8'h10;
    localparam logic [DATA_W-1:0] CMD_SECT_ARM   = 8'h20;
    localparam logic [DATA_W-1:0] CMD_SECT_GO    = 8'hD0;
    localparam logic [DATA_W-1:0] CMD_CHIP       = 8'h30;
    localparam logic [DATA_W-1:0] CMD_IDENT      = 8'h90;
    localparam logic [DATA_W-1:0] CMD_ABORT      = 8'hFF;
    localparam logic [DATA_W-1:0] ID_MAKER       = 8'hBF;
    localparam logic [DATA_W-1:0] ID_PART        = 8'h04;
    localparam logic [DATA_W-1:0] ERASED         = 8'hFF;

    typedef enum logic [2:0] {
        ST_READ,
        ST_IDENT,
        ST_SECT_ARM,
        ST_CHIP_ARM,
        ST_PROG_ARM,
        ST_BUSY
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SECT,
        OP_CHIP,
        OP_PROG
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [DATA_W-1:0] data;
    } op_req_t;

    typedef struct packed {
        logic wr_go;
        logic rd_end;
    } bus_evt_t;

    // next mode for a command written in read or identification mode
    function automatic seq_state_e entry_state(seq_state_e cur, logic [DATA_W-1:0] d);
        seq_state_e nxt;
        unique case (d)
            CMD_SECT_ARM: nxt = ST_SECT_ARM;
            CMD_CHIP:     nxt = ST_CHIP_ARM;
            CMD_PROG:     nxt = ST_PROG_ARM;
            CMD_IDENT:    nxt = ST_IDENT;
            CMD_ABORT:    nxt = ST_READ;
            default:      nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/flashcmd_bus_sampler.sv
`timescale 1ns/1ps
module flashcmd_bus_sampler
    import flashcmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     oe_n,
    input  logic     we_n,
    output bus_evt_t evt,
    output logic     rd_on
);

    logic wr_lvl;
    logic wr_q;
    logic rd_q;

    assign wr_lvl = !cs_n && !we_n && oe_n;   // R1
    assign rd_on  = !cs_n && !oe_n && we_n;   // R11

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_lvl;
            rd_q <= rd_on;
        end
    end

    always_comb begin
        evt.wr_go  = wr_lvl && !wr_q;
        evt.rd_end = rd_q && !rd_on;
    end

endmodule

// File: rtl/flashcmd_cmd_fsm.sv
`timescale 1ns/1ps
module flashcmd_cmd_fsm
    import flashcmd_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int T_SECT = 40,
    parameter int T_CHIP = 120,
    parameter int T_PROG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock,
    input  bus_evt_t          evt,
    input  logic [MEM_AW-1:0] addr_lo,
    input  logic [DATA_W-1:0] din,
    input  logic              old_msb,
    output seq_state_e        st,
    output op_req_t           op,
    output logic [MEM_AW-1:0] op_addr,
    output logic              commit,
    output logic              tgl,
    output logic              fin7
);

    localparam int T_MAX = (T_SECT > T_CHIP) ? ((T_SECT > T_PROG) ? T_SECT : T_PROG)
                                             : ((T_CHIP > T_PROG) ? T_CHIP : T_PROG);
    localparam int CNT_W = $clog2(T_MAX + 1);

    logic [CNT_W-1:0] cnt;
    seq_state_e       nxt_st;
    logic             launch;
    op_kind_e         l_kind;
    logic [CNT_W-1:0] l_len;

    always_comb begin
        nxt_st = st;
        launch = 1'b0;
        l_kind = OP_NONE;
        l_len  = '0;
        if (st != ST_BUSY && evt.wr_go && unlock) begin          // R2
            unique case (st)
                ST_SECT_ARM: begin
                    if (din == CMD_SECT_GO) begin                 // R5
                        launch = 1'b1;
                        l_kind = OP_SECT;
                        l_len  = CNT_W'(T_SECT - 1);
                    end else begin
                        nxt_st = ST_READ;                         // R7
                    end
                end
                ST_CHIP_ARM: begin
                    if (din == CMD_CHIP) begin                    // R6
                        launch = 1'b1;
                        l_kind = OP_CHIP;
                        l_len  = CNT_W'(T_CHIP - 1);
                    end else begin
                        nxt_st = ST_READ;
                    end
                end
                ST_PROG_ARM: begin
                    if (din == CMD_ABORT) begin
                        nxt_st = ST_READ;
                    end else begin                                // R4
                        launch = 1'b1;
                        l_kind = OP_PROG;
                        l_len  = CNT_W'(T_PROG - 1);
                    end
                end
                default: nxt_st = entry_state(st, din);           // R3
            endcase
            if (launch) nxt_st = ST_BUSY;
        end
    end

    assign commit = (st == ST_BUSY) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_READ;                                   // R12
            cnt     <= '0;
            op      <= '0;
            op_addr <= '0;
            tgl     <= 1'b0;
            fin7    <= 1'b0;
        end else if (st == ST_BUSY) begin                         // R10
            if (evt.rd_end) tgl <= ~tgl;                          // R9
            if (cnt == '0) st <= ST_READ;
            else           cnt <= cnt - 1'b1;
        end else begin
            st <= nxt_st;
            if (launch) begin
                cnt     <= l_len;
                op      <= '{kind: l_kind, data: din};
                op_addr <= addr_lo;
                tgl     <= 1'b0;
                fin7    <= (l_kind == OP_PROG) ? (old_msb & din[DATA_W-1]) : 1'b1;  // R8
            end
        end
    end

endmodule

// File: rtl/flashcmd_cell_array.sv
`timescale 1ns/1ps
module flashcmd_cell_array
    import flashcmd_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  op_req_t           op,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] cells [DEPTH];

    function automatic logic same_sector(int i, logic [MEM_AW-1:0] wa);
        logic [MEM_AW-1:0] ix;
        ix = MEM_AW'(i);
        return ix[MEM_AW-1:SECT_LSB] == wa[MEM_AW-1:SECT_LSB];
    endfunction

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                cells[i] <= ERASED;                               // R12
            end else if (commit) begin
                unique case (op.kind)
                    OP_SECT: if (same_sector(i, waddr)) cells[i] <= ERASED;          // R5
                    OP_CHIP: cells[i] <= ERASED;                                     // R6
                    OP_PROG: if (MEM_AW'(i) == waddr) cells[i] <= cells[i] & op.data; // R4
                    default: ;
                endcase
            end
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/flashcmd_seq.sv
`timescale 1ns/1ps
module flashcmd_seq
    import flashcmd_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int T_SECT = 40,
    parameter int T_CHIP = 120,
    parameter int T_PROG = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic        unlock,
    input  logic [18:0] addr,
    input  logic [7:0]  din,
    output logic [7:0]  dout,
    output logic        dout_en
);

    bus_evt_t          evt;
    logic              rd_on;
    logic              wr_go;
    logic              rd_end;
    seq_state_e        st;
    op_req_t           op;
    logic [MEM_AW-1:0] op_addr;
    logic              commit;
    logic              tgl;
    logic              fin7;
    logic [DATA_W-1:0] cell_byte;

    assign wr_go  = evt.wr_go;
    assign rd_end = evt.rd_end;

    flashcmd_bus_sampler u_bus (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .evt   (evt),
        .rd_on (rd_on)
    );

    flashcmd_cmd_fsm #(
        .MEM_AW (MEM_AW),
        .T_SECT (T_SECT),
        .T_CHIP (T_CHIP),
        .T_PROG (T_PROG)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .unlock  (unlock),
        .evt     (evt),
        .addr_lo (addr[MEM_AW-1:0]),
        .din     (din),
        .old_msb (cell_byte[DATA_W-1]),
        .st      (st),
        .op      (op),
        .op_addr (op_addr),
        .commit  (commit),
        .tgl     (tgl),
        .fin7    (fin7)
    );

    flashcmd_cell_array #(
        .MEM_AW (MEM_AW)
    ) u_cells (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .op     (op),
        .waddr  (op_addr),
        .raddr  (addr[MEM_AW-1:0]),
        .rdata  (cell_byte)
    );

    always_comb begin
        dout_en = rd_on;                                          // R11
        if (st == ST_BUSY) begin
            dout = {~fin7, tgl, cell_byte[5:0]};                  // R8 R9
        end else if (st == ST_IDENT) begin
            if (addr == 19'd0)      dout = ID_MAKER;              // R3
            else if (addr == 19'd1) dout = ID_PART;
            else                    dout = 8'h00;
        end else begin
            dout = cell_byte;
        end
    end

endmodule

// File: rtl/flashcmd_seq_chk.sv
`timescale 1ns/1ps
module flashcmd_seq_chk
    import flashcmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       oe_n,
    input logic       unlock,
    input logic [7:0] din,
    input seq_state_e st,
    input logic       wr_go,
    input logic       rd_end,
    input logic       tgl,
    input logic       commit
);

    AST_OE_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!oe_n && st != ST_BUSY) |=> (st == $past(st))) else $error("oe"); // R1

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!unlock && st != ST_BUSY) |=> (st == $past(st))) else $error("lock"); // R2

    AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDENT && $past(st) != ST_IDENT) |-> ($past(wr_go) && $past(din) == CMD_IDENT)) else $error("id"); // R3

    AST_ABORT_TO_READ: assert property (@(posedge clk) disable iff (rst)
        (wr_go && unlock && din == CMD_ABORT &&
         (st == ST_SECT_ARM || st == ST_CHIP_ARM || st == ST_PROG_ARM)) |=> (st == ST_READ)) else $error("abort"); // R7

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSY && rd_end) |=> (tgl != $past(tgl))) else $error("tgl"); // R9

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        commit |=> (st == ST_READ)) else $error("end"); // R10

endmodule

bind flashcmd_seq flashcmd_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .oe_n   (oe_n),
    .unlock (unlock),
    .din    (din),
    .st     (st),
    .wr_go  (wr_go),
    .rd_end (rd_end),
    .tgl    (tgl),
    .commit (commit)
);

// File: tb/test_flashcmd_seq.sv
`timescale 1ns/1ps
module test_flashcmd_seq;

    localparam int MEM_AW = 10;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int T_SECT = 40;
    localparam int T_CHIP = 120;
    localparam int T_PROG = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        cs_n, oe_n, we_n, unlock;
    logic [18:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en;

    always #2 clk = ~clk;   // 250 MHz

    flashcmd_seq #(
        .MEM_AW (MEM_AW), .T_SECT (T_SECT), .T_CHIP (T_CHIP), .T_PROG (T_PROG)
    ) i_flashcmd_seq (
        .clk (clk), .rst (rst), .cs_n (cs_n), .oe_n (oe_n), .we_n (we_n),
        .unlock (unlock), .addr (addr), .din (din), .dout (dout), .dout_en (dout_en)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string phase  = "R12";

    // behavioural reference: mode 0 read, 1 ident, 2 sector armed, 3 chip armed, 4 program armed, 5 busy
    int m_mem [DEPTH];
    int m_mode, m_cnt, m_kind, m_tgl, m_fin7, m_addr, m_data;
    bit m_pwr, m_prd;

    task automatic m_launch(int kind, int len, int a);
        m_kind = kind;
        m_cnt  = len - 1;
        m_addr = a;
        m_data = din;
        m_tgl  = 0;
        m_fin7 = (kind == 3) ? (((m_mem[a] & din) >> 7) & 1) : 1;
        m_mode = 5;
    endtask

    always @(posedge clk) begin : model
        bit wr, rd, go, rend;
        int a;
        wr   = !cs_n && !we_n && oe_n;
        rd   = !cs_n && !oe_n && we_n;
        go   = wr && !m_pwr;
        rend = m_prd && !rd;
        a    = int'(addr) % DEPTH;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 255;
            m_mode = 0; m_cnt = 0; m_tgl = 0; m_fin7 = 0; m_kind = 0;
            m_pwr = 0; m_prd = 0;
        end else begin
            if (m_mode == 5) begin
                if (rend) m_tgl = m_tgl ^ 1;
                if (m_cnt == 0) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (m_kind == 1 && (i / 256) == (m_addr / 256)) m_mem[i] = 255;
                        if (m_kind == 2) m_mem[i] = 255;
                    end
                    if (m_kind == 3) m_mem[m_addr] = m_mem[m_addr] & m_data;
                    m_mode = 0;
                end else begin
                    m_cnt--;
                end
            end else if (go && unlock) begin
                case (m_mode)
                    2: if (din == 8'hD0) m_launch(1, T_SECT, a); else m_mode = 0;
                    3: if (din == 8'h30) m_launch(2, T_CHIP, a); else m_mode = 0;
                    4: if (din == 8'hFF) m_mode = 0; else m_launch(3, T_PROG, a);
                    default: begin
                        case (din)
                            8'h20: m_mode = 2;
                            8'h30: m_mode = 3;
                            8'h10: m_mode = 4;
                            8'h90: m_mode = 1;
                            8'hFF: m_mode = 0;
                            default: ;
                        endcase
                    end
                endcase
            end
            m_pwr = wr;
            m_prd = rd;
        end
    end

    function automatic int model_dout();
        int a;
        a = int'(addr) % DEPTH;
        if (m_mode == 5) return ((1 - m_fin7) << 7) | (m_tgl << 6) | (m_mem[a] & 63);
        if (m_mode == 1) return (addr == 0) ? 8'hBF : ((addr == 1) ? 8'h04 : 8'h00);
        return m_mem[a];
    endfunction

    // per-clock comparison, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            bit exp_en;
            exp_en = !cs_n && !oe_n && we_n;
            n_chk++;
            if (dout_en !== exp_en) begin
                n_fail++;
                $display("FAIL %s/R11 dout_en actual %0b expected %0b at %0t", phase, dout_en, exp_en, $time);
            end
            if (exp_en) begin
                n_chk++;
                if (int'(dout) != model_dout()) begin
                    n_fail++;
                    $display("FAIL %s dout actual %02h expected %02h at %0t", phase, dout, model_dout(), $time);
                end
            end
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(posedge clk);
        #1 v = dout;
        @(negedge clk);
        cs_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        logic [7:0] v;
        rst = 1'b1; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; unlock = 1'b0;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        phase = "R12";
        check("R12 bus idle after reset", {7'd0, dout_en}, 8'h00);
        rd(19'h5, v);  check("R12 erased after reset", v, 8'hFF);

        phase = "R2";   // locked: writes ignored
        wr(19'h0, 8'h90);
        rd(19'h0, v);  check("R2 ident not entered while locked", v, 8'hFF);
        wr(19'h0, 8'h10); wr(19'h5, 8'h00); idle(T_PROG + 4);
        rd(19'h5, v);  check("R2 program ignored while locked", v, 8'hFF);

        unlock = 1'b1;
        phase = "R3";
        wr(19'h0, 8'h90);
        rd(19'h0, v);  check("R3 maker code", v, 8'hBF);
        rd(19'h1, v);  check("R3 part code", v, 8'h04);
        rd(19'h2, v);  check("R3 other address", v, 8'h00);
        wr(19'h0, 8'hFF);
        rd(19'h0, v);  check("R3 abort leaves ident", v, 8'hFF);

        phase = "R1";   // strobe combinations that are not writes
        @(negedge clk); cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; din = 8'h90; addr = '0;
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        rd(19'h0, v);  check("R1 write with oe_n low ignored", v, 8'hFF);
        @(negedge clk); cs_n = 1'b1; we_n = 1'b0; oe_n = 1'b1; din = 8'h90;
        @(negedge clk); we_n = 1'b1;
        rd(19'h0, v);  check("R1 write with cs_n high ignored", v, 8'hFF);

        phase = "R4";
        wr(19'h0, 8'h10); wr(19'h105, 8'h3C);
        rd(19'h105, v); check("R8 status bit7 inverted, R9 toggle 0", v, 8'hBF);
        rd(19'h105, v); check("R9 toggle flipped", v, 8'hFF);
        idle(T_PROG + 2);
        rd(19'h105, v); check("R4 programmed byte", v, 8'h3C);
        wr(19'h0, 8'h10); wr(19'h105, 8'hF0); idle(T_PROG + 2);
        rd(19'h105, v); check("R4 program ANDs into cell", v, 8'h30);

        phase = "R7";
        wr(19'h0, 8'h10); wr(19'h105, 8'hFF);
        rd(19'h105, v); check("R7 program abort", v, 8'h30);
        wr(19'h0, 8'h20); wr(19'h105, 8'h55); idle(T_SECT + 4);
        rd(19'h105, v); check("R7 wrong confirm abandons erase", v, 8'h30);
        wr(19'h0, 8'h30); wr(19'h0, 8'hFF); idle(T_CHIP + 4);
        rd(19'h105, v); check("R7 chip erase abort", v, 8'h30);

        phase = "R5";
        wr(19'h0, 8'h10); wr(19'h210, 8'h00); idle(T_PROG + 2);
        wr(19'h0, 8'h10); wr(19'h305, 8'h55); idle(T_PROG + 2);
        wr(19'h0, 8'h20); wr(19'h2AA, 8'hD0);
        rd(19'h210, v); check("R8 erase status bit7 low", v, 8'h00);
        idle(T_SECT + 2);
        rd(19'h210, v); check("R5 sector erased", v, 8'hFF);
        rd(19'h305, v); check("R5 other sector kept", v, 8'h55);
        rd(19'h105, v); check("R5 lower sector kept", v, 8'h30);

        phase = "R10";
        wr(19'h0, 8'h30); wr(19'h0, 8'h30);
        wr(19'h0, 8'h90);                       // ignored while busy
        idle(T_CHIP + 4);
        rd(19'h0, v);   check("R10 write during busy ignored", v, 8'hFF);
        phase = "R6";
        rd(19'h305, v); check("R6 chip erase", v, 8'hFF);
        rd(19'h105, v); check("R6 chip erase low byte", v, 8'hFF);

        phase = "R3";
        wr(19'h0, 8'h90); wr(19'h0, 8'h10); wr(19'h7, 8'h81); idle(T_PROG + 2);
        rd(19'h0, v);   check("R3 program code leaves ident", v, 8'hFF);
        rd(19'h7, v);   check("R3 program after ident", v, 8'h81);

        idle(4);
        finish_run();
    end

endmodule